// File: doc/BRIEF.md
# Status Sampler and Urgent Event Interrupter

This block sits between a target board and a host that runs a slow software model. Routine status is collected on a timer. Each time a programmable interval expires, the block copies the target's status word and its own status word into registers the host can read. It tags every copy with an incrementing sequence number and a flag that says the copy is new and not yet read. The host collects these copies by polling, whenever it likes.

Urgent target events, such as a board interrupt or a board reset, do not wait for a poll. Each event line passes through a synchronizer and an edge detector. A detected edge sets a sticky pending bit, and any pending bit the host has unmasked drives a single interrupt line towards the host straight away. The host clears pending bits by writing ones to them. Reading the snapshot information register consumes the new-copy flag.

Top module: `status_irq_sampler`

## Requirements
- R1: After reset the interval, mask, pending bits, both snapshots and the information word all read as zero, and `host_irq` is low.
- R2: With a nonzero interval N written to address 0, the block captures `tgt_status` into address 3 and `own_status` into address 4 exactly N clock edges after the write, and every N edges after that.
- R3: An interval of zero stops sampling, so the information word does not change. Writing address 0 restarts the count from zero, and no capture happens on the edge of that write.
- R4: Each capture increments the sequence number in the low SEQ_W bits of address 5. The number wraps modulo 2^SEQ_W, so the first capture after reset carries 1.
- R5: Bit DATA_W-1 of address 5 is a new-copy flag. A capture sets it. A read of address 5 clears it, together with the lost flag, unless a capture happens on the same edge, in which case the flag stays set.
- R6: Bit DATA_W-2 of address 5 is a lost flag. It is set when a capture replaces a copy whose new-copy flag was still set and that was not read on the same edge.
- R7: A rising edge on an `evt_async` bit sets the matching pending bit in address 2 on the third clock edge after the level changes. A level that stays high does not set the bit again once the host has cleared it.
- R8: A write to address 2 clears exactly the pending bits written as one and leaves the others set. If an edge sets a bit on the same edge as a clear, the bit stays set.
- R9: `host_irq` is high exactly when some pending bit is set whose bit in the mask at address 1 is one. A masked pending bit stays pending but does not raise the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Register address for reads and writes |
| host_wr | input | 1 | Write strobe, takes effect at the clock edge |
| host_wdata | input | DATA_W | Write data |
| host_rd | input | 1 | Read strobe, used for the read side effect of address 5 |
| host_rdata | output | DATA_W | Read data for `host_addr`, combinational |
| tgt_status | input | TGT_W | Target status word, sampled on each capture |
| own_status | input | OWN_W | Block's own status word, sampled on each capture |
| evt_async | input | N_EVT | Urgent event lines from the target, asynchronous |
| host_irq | output | 1 | Interrupt towards the host |

## Verification
The bench builds the block with a 3-bit sequence number, an 8-bit interval and a 16-bit data word. The narrow sequence number lets the run wrap it after a few captures. A one-cycle interval can then force back-to-back captures, which produce the lost flag and a read on the same edge as a capture. Two event lines with two synchronizer stages let the bench check mask gating and the case where a set and a clear land on the same edge, and confirm the exact three-edge latency.

// File: rtl/sti_pkg.sv
package sti_pkg;
   // register addresses decoded by the host port
   typedef enum logic [2:0] {
      REG_INTV = 3'd0,
      REG_MASK = 3'd1,
      REG_PEND = 3'd2,
      REG_SNPT = 3'd3,
      REG_SNPO = 3'd4,
      REG_INFO = 3'd5
   } sti_reg_e;

   localparam int unsigned STI_ADDR_BITS = 3;

   // edge detection flavours for the event synchronizer
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_ANY  = 1'b1
   } sti_edge_e;
endpackage

// File: rtl/sti_sync_edge.sv
module sti_sync_edge #(
   parameter int unsigned N_BITS      = 2,
   parameter int unsigned STAGES      = 2,
   parameter bit          DETECT_ANY  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] async_in,
   output logic [N_BITS-1:0] edge_out
);
   localparam int unsigned LAST = STAGES - 1;

   logic [N_BITS-1:0] chain_q [STAGES];
   logic [N_BITS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
         prev_q <= chain_q[LAST];
      end
   end

   generate
      if (DETECT_ANY) begin : g_any
         assign edge_out = chain_q[LAST] ^ prev_q;
      end else begin : g_rise
         assign edge_out = chain_q[LAST] & ~prev_q;
      end
   endgenerate
endmodule

// File: rtl/sti_interval_timer.sv
module sti_interval_timer #(
   parameter int unsigned INTV_W = 16,
   parameter int unsigned SEQ_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              intv_we,
   input  logic [INTV_W-1:0] intv_wdata,
   output logic [INTV_W-1:0] intv_o,
   output logic              tick_o,
   output logic [SEQ_W-1:0]  seq_o
);
   logic [INTV_W-1:0] intv_q;
   logic [INTV_W-1:0] cnt_q;
   logic [SEQ_W-1:0]  seq_q;
   logic              running;
   logic              at_end;

   assign running = (intv_q != '0);
   assign at_end  = (cnt_q == intv_q - 1'b1);
   // a write to the interval preempts a capture on the same edge
   assign tick_o  = running && at_end && !intv_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intv_q <= '0;
         cnt_q  <= '0;
         seq_q  <= '0;
      end else if (intv_we) begin
         intv_q <= intv_wdata;
         cnt_q  <= '0;
      end else if (tick_o) begin
         cnt_q  <= '0;
         seq_q  <= seq_q + 1'b1;
      end else if (running) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign intv_o = intv_q;
   assign seq_o  = seq_q;
endmodule

// File: rtl/sti_snapshot.sv
module sti_snapshot #(
   parameter int unsigned TGT_W = 8,
   parameter int unsigned OWN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             rd_clr_i,
   input  logic [TGT_W-1:0] tgt_i,
   input  logic [OWN_W-1:0] own_i,
   output logic [TGT_W-1:0] tgt_o,
   output logic [OWN_W-1:0] own_o,
   output logic             fresh_o,
   output logic             lost_o
);
   logic [TGT_W-1:0] tgt_q;
   logic [OWN_W-1:0] own_q;
   logic             fresh_q;
   logic             lost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q   <= '0;
         own_q   <= '0;
         fresh_q <= 1'b0;
         lost_q  <= 1'b0;
      end else if (tick_i) begin
         tgt_q   <= tgt_i;
         own_q   <= own_i;
         fresh_q <= 1'b1;
         // a read on this edge consumed the old copy and its flags
         lost_q  <= rd_clr_i ? 1'b0 : (lost_q | fresh_q);
      end else if (rd_clr_i) begin
         fresh_q <= 1'b0;
         lost_q  <= 1'b0;
      end
   end

   assign tgt_o   = tgt_q;
   assign own_o   = own_q;
   assign fresh_o = fresh_q;
   assign lost_o  = lost_q;
endmodule

// File: rtl/sti_event_bank.sv
module sti_event_bank #(
   parameter int unsigned N_EVT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] edge_i,
   input  logic             clr_we,
   input  logic [N_EVT-1:0] clr_bits,
   input  logic             mask_we,
   input  logic [N_EVT-1:0] mask_wdata,
   output logic [N_EVT-1:0] pend_o,
   output logic [N_EVT-1:0] mask_o,
   output logic             irq_o
);
   logic [N_EVT-1:0] pend_q;
   logic [N_EVT-1:0] mask_q;
   logic [N_EVT-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_bits : '0;

   generate
      for (genvar i = 0; i < N_EVT; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q[i] <= 1'b0;
            end else if (edge_i[i]) begin
               pend_q[i] <= 1'b1;
            end else if (clr_eff[i]) begin
               pend_q[i] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else if (mask_we) mask_q <= mask_wdata;
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign irq_o  = |(pend_q & mask_q);
endmodule

// File: rtl/status_irq_sampler.sv
module status_irq_sampler
   import sti_pkg::*;
#(
   parameter int unsigned N_EVT       = 2,
   parameter int unsigned TGT_W       = 8,
   parameter int unsigned OWN_W       = 8,
   parameter int unsigned INTV_W      = 16,
   parameter int unsigned SEQ_W       = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          DETECT_ANY  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [TGT_W-1:0]  tgt_status,
   input  logic [OWN_W-1:0]  own_status,
   input  logic [N_EVT-1:0]  evt_async,
   output logic              host_irq
);
   localparam int unsigned FRESH_BIT = DATA_W - 1;
   localparam int unsigned LOST_BIT  = DATA_W - 2;

   generate
      if (ADDR_W < STI_ADDR_BITS) begin : g_bad_addr
         $error("status_irq_sampler: ADDR_W too narrow for the register map");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("status_irq_sampler: SYNC_STAGES must be at least 2");
      end
      if (N_EVT < 1 || N_EVT > DATA_W) begin : g_bad_evt
         $error("status_irq_sampler: N_EVT out of range");
      end
      if (TGT_W > DATA_W || OWN_W > DATA_W || INTV_W > DATA_W) begin : g_bad_w
         $error("status_irq_sampler: a field is wider than DATA_W");
      end
      if (SEQ_W + 2 > DATA_W) begin : g_bad_seq
         $error("status_irq_sampler: SEQ_W leaves no room for flags");
      end
   endgenerate

   logic [2:0] reg_sel;
   logic       addr_hi_zero;
   assign reg_sel = host_addr[2:0];
   generate
      if (ADDR_W > STI_ADDR_BITS) begin : g_hi
         assign addr_hi_zero = (host_addr[ADDR_W-1:STI_ADDR_BITS] == '0);
      end else begin : g_nohi
         assign addr_hi_zero = 1'b1;
      end
   endgenerate

   logic hit_intv, hit_mask, hit_pend, hit_info;
   assign hit_intv = addr_hi_zero && (reg_sel == REG_INTV);
   assign hit_mask = addr_hi_zero && (reg_sel == REG_MASK);
   assign hit_pend = addr_hi_zero && (reg_sel == REG_PEND);
   assign hit_info = addr_hi_zero && (reg_sel == REG_INFO);

   logic [N_EVT-1:0]  edge_w;
   logic [N_EVT-1:0]  pend_w;
   logic [N_EVT-1:0]  mask_w;
   logic [INTV_W-1:0] intv_w;
   logic [SEQ_W-1:0]  seq_w;
   logic              tick_w;
   logic              rd_clr_w;
   logic [TGT_W-1:0]  snap_tgt_w;
   logic [OWN_W-1:0]  snap_own_w;
   logic              fresh_w;
   logic              lost_w;

   assign rd_clr_w = host_rd && hit_info;

   sti_sync_edge #(
      .N_BITS    (N_EVT),
      .STAGES    (SYNC_STAGES),
      .DETECT_ANY(DETECT_ANY)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(evt_async),
      .edge_out(edge_w)
   );

   sti_interval_timer #(
      .INTV_W(INTV_W),
      .SEQ_W (SEQ_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .intv_we   (host_wr && hit_intv),
      .intv_wdata(host_wdata[INTV_W-1:0]),
      .intv_o    (intv_w),
      .tick_o    (tick_w),
      .seq_o     (seq_w)
   );

   sti_snapshot #(
      .TGT_W(TGT_W),
      .OWN_W(OWN_W)
   ) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_w),
      .rd_clr_i(rd_clr_w),
      .tgt_i   (tgt_status),
      .own_i   (own_status),
      .tgt_o   (snap_tgt_w),
      .own_o   (snap_own_w),
      .fresh_o (fresh_w),
      .lost_o  (lost_w)
   );

   sti_event_bank #(
      .N_EVT(N_EVT)
   ) u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_i    (edge_w),
      .clr_we    (host_wr && hit_pend),
      .clr_bits  (host_wdata[N_EVT-1:0]),
      .mask_we   (host_wr && hit_mask),
      .mask_wdata(host_wdata[N_EVT-1:0]),
      .pend_o    (pend_w),
      .mask_o    (mask_w),
      .irq_o     (host_irq)
   );

   always_comb begin
      host_rdata = '0;
      if (addr_hi_zero) begin
         case (reg_sel)
            REG_INTV: host_rdata[INTV_W-1:0] = intv_w;
            REG_MASK: host_rdata[N_EVT-1:0]  = mask_w;
            REG_PEND: host_rdata[N_EVT-1:0]  = pend_w;
            REG_SNPT: host_rdata[TGT_W-1:0]  = snap_tgt_w;
            REG_SNPO: host_rdata[OWN_W-1:0]  = snap_own_w;
            REG_INFO: begin
               host_rdata[SEQ_W-1:0] = seq_w;
               host_rdata[LOST_BIT]  = lost_w;
               host_rdata[FRESH_BIT] = fresh_w;
            end
            default:  host_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/status_irq_sampler_chk.sv
module status_irq_sampler_chk #(
   parameter int unsigned N_EVT  = 2,
   parameter int unsigned INTV_W = 16,
   parameter int unsigned SEQ_W  = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [DATA_W-1:0] host_wdata,
   input logic              host_irq,
   input logic [N_EVT-1:0]  pend,
   input logic [N_EVT-1:0]  mask,
   input logic [INTV_W-1:0] intv,
   input logic [SEQ_W-1:0]  seq,
   input logic              fresh,
   input logic              tick
);
   logic             pend_wr;
   logic             info_rd;
   logic [N_EVT-1:0] keep;

   assign pend_wr = host_wr && (host_addr == ADDR_W'(2));
   assign info_rd = host_rd && (host_addr == ADDR_W'(5));
   assign keep    = pend & ~(pend_wr ? host_wdata[N_EVT-1:0] : '0);

   // R1: nothing pending and no interrupt while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_quiet_in_reset_R1: assert (!host_irq && pend == '0);
      end
   end

   // R3: an idle interval leaves the sequence number alone
   assert_no_sample_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (intv == '0 && $past(intv) == '0) |-> $stable(seq));

   // R4: the sequence only ever steps by one, and a step marks a new copy
   assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seq != $past(seq)) |-> (seq == $past(seq) + 1'b1) && fresh);

   // R5: a read of the information word without a capture consumes the flag
   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(info_rd && !tick) |-> !fresh);

   // R8: pending bits not cleared by the host stay set
   assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(keep)) == $past(keep)));

   // R9: with every source masked the line stays low
   assert_mask_gates_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !host_irq);
endmodule

bind status_irq_sampler status_irq_sampler_chk #(
   .N_EVT (N_EVT),
   .INTV_W(INTV_W),
   .SEQ_W (SEQ_W),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_addr (host_addr),
   .host_wr   (host_wr),
   .host_rd   (host_rd),
   .host_wdata(host_wdata),
   .host_irq  (host_irq),
   .pend      (pend_w),
   .mask      (mask_w),
   .intv      (intv_w),
   .seq       (seq_w),
   .fresh     (fresh_w),
   .tick      (tick_w)
);

// File: tb/status_irq_sampler_bench.sv
module status_irq_sampler_bench;
   localparam int unsigned N_EVT  = 2;
   localparam int unsigned TGT_W  = 8;
   localparam int unsigned OWN_W  = 8;
   localparam int unsigned INTV_W = 8;
   localparam int unsigned SEQ_W  = 3;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned ADDR_W = 3;

   // operation codes of the vector table
   localparam int OP_WR   = 0;  // write data to addr
   localparam int OP_RD   = 1;  // read addr with strobe, compare with exp
   localparam int OP_WAIT = 2;  // idle for data edges
   localparam int OP_SET  = 3;  // tgt_status = data[15:8], evt = data[1:0]
   localparam int OP_IRQ  = 4;  // compare host_irq with exp[0]

   localparam int A_INTV = 0, A_MASK = 1, A_PEND = 2, A_SNPT = 3, A_SNPO = 4, A_INFO = 5;

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  addr;
      logic [15:0] data;
      logic [15:0] exp;
      logic [3:0]  req;
   } vec_t;

   function automatic vec_t mk(int op, int addr, int data, int exp, int req);
      vec_t v;
      v.op = 3'(op); v.addr = 3'(addr); v.data = 16'(data);
      v.exp = 16'(exp); v.req = 4'(req);
      return v;
   endfunction

   localparam int NV = 57;
   localparam vec_t VEC [NV] = '{
      mk(OP_RD,   A_PEND, 0,      16'h0000, 1),  // R1
      mk(OP_RD,   A_INFO, 0,      16'h0000, 1),  // R1
      mk(OP_RD,   A_SNPT, 0,      16'h0000, 1),  // R1
      mk(OP_IRQ,  0,      0,      16'h0000, 1),  // R1
      mk(OP_SET,  0,      16'hA500, 0,      0),
      mk(OP_WR,   A_INTV, 4,      0,        0),
      mk(OP_WAIT, 0,      3,      0,        0),
      mk(OP_RD,   A_INFO, 0,      16'h0000, 2),  // R2: no capture before N edges
      mk(OP_RD,   A_SNPT, 0,      16'h00A5, 2),  // R2
      mk(OP_RD,   A_SNPO, 0,      16'h005A, 2),  // R2
      mk(OP_RD,   A_INFO, 0,      16'h8001, 4),  // R4: first copy carries 1
      mk(OP_RD,   A_INFO, 0,      16'h0001, 5),  // R5: flag consumed
      mk(OP_SET,  0,      16'h1100, 0,      0),
      mk(OP_WAIT, 0,      3,      0,        0),
      mk(OP_RD,   A_INFO, 0,      16'hC003, 6),  // R6: unread copy replaced
      mk(OP_RD,   A_SNPT, 0,      16'h0011, 2),  // R2: periodic capture
      mk(OP_RD,   A_INFO, 0,      16'h0003, 5),  // R5: lost also cleared
      mk(OP_WR,   A_INTV, 0,      0,        0),
      mk(OP_WAIT, 0,      10,     0,        0),
      mk(OP_RD,   A_INFO, 0,      16'h0003, 3),  // R3: sampling stopped
      mk(OP_RD,   A_INTV, 0,      16'h0000, 3),  // R3
      mk(OP_WR,   A_MASK, 1,      0,        0),
      mk(OP_SET,  0,      16'h1101, 0,      0),
      mk(OP_RD,   A_PEND, 0,      16'h0000, 7),  // R7: not yet
      mk(OP_RD,   A_PEND, 0,      16'h0000, 7),  // R7: not yet
      mk(OP_RD,   A_PEND, 0,      16'h0001, 7),  // R7: third edge
      mk(OP_IRQ,  0,      0,      16'h0001, 9),  // R9
      mk(OP_SET,  0,      16'h1103, 0,      0),
      mk(OP_WAIT, 0,      2,      0,        0),
      mk(OP_RD,   A_PEND, 0,      16'h0003, 7),  // R7
      mk(OP_WR,   A_PEND, 1,      0,        0),
      mk(OP_RD,   A_PEND, 0,      16'h0002, 8),  // R8: only bit 0 cleared
      mk(OP_WAIT, 0,      3,      0,        0),
      mk(OP_RD,   A_PEND, 0,      16'h0002, 7),  // R7: held level no relatch
      mk(OP_IRQ,  0,      0,      16'h0000, 9),  // R9: bit 1 masked
      mk(OP_WR,   A_MASK, 3,      0,        0),
      mk(OP_IRQ,  0,      0,      16'h0001, 9),  // R9
      mk(OP_WR,   A_PEND, 2,      0,        0),
      mk(OP_RD,   A_PEND, 0,      16'h0000, 8),  // R8
      mk(OP_IRQ,  0,      0,      16'h0000, 9),  // R9
      mk(OP_SET,  0,      16'h1100, 0,      0),
      mk(OP_WAIT, 0,      3,      0,        0),
      mk(OP_SET,  0,      16'h1101, 0,      0),
      mk(OP_WAIT, 0,      1,      0,        0),
      mk(OP_WR,   A_PEND, 1,      0,        0),  // clear on the set edge
      mk(OP_RD,   A_PEND, 0,      16'h0001, 8),  // R8: set wins
      mk(OP_IRQ,  0,      0,      16'h0001, 9),  // R9
      mk(OP_SET,  0,      16'h3300, 0,      0),
      mk(OP_WR,   A_INTV, 1,      0,        0),
      mk(OP_WAIT, 0,      5,      0,        0),
      mk(OP_WR,   A_INTV, 0,      0,        0),  // R3: no capture on write edge
      mk(OP_RD,   A_INFO, 0,      16'hC000, 4),  // R4: wrapped to 0, R6 lost
      mk(OP_RD,   A_SNPO, 0,      16'h00CC, 2),  // R2
      mk(OP_WR,   A_PEND, 1,      0,        0),
      mk(OP_RD,   A_PEND, 0,      16'h0000, 8),  // R8
      mk(OP_RD,   A_MASK, 0,      16'h0003, 9),  // R9
      mk(OP_SET,  0,      16'h3300, 0,      0)
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic              host_wr = 1'b0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic              host_rd = 1'b0;
   logic [DATA_W-1:0] host_rdata;
   logic [TGT_W-1:0]  tgt_status = '0;
   logic [OWN_W-1:0]  own_status;
   logic [N_EVT-1:0]  evt_async = '0;
   logic              host_irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   assign own_status = ~tgt_status;

   always #10 clk = ~clk;  // 50 MHz

   status_irq_sampler #(
      .N_EVT (N_EVT), .TGT_W(TGT_W), .OWN_W(OWN_W), .INTV_W(INTV_W),
      .SEQ_W (SEQ_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .SYNC_STAGES(2), .DETECT_ANY(1'b0)
   ) u_status_irq_sampler (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
      .tgt_status(tgt_status), .own_status(own_status),
      .evt_async(evt_async), .host_irq(host_irq)
   );

   task automatic check(int req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   // one edge: inputs set after the falling edge, results read before the rising one
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      host_wr = 1'b0;
      host_rd = 1'b0;
   endtask

   task automatic run_vec(vec_t v);
      case (int'(v.op))
         OP_WR: begin
            host_addr = v.addr; host_wdata = v.data; host_wr = 1'b1;
            step();
         end
         OP_RD: begin
            host_addr = v.addr; host_rd = 1'b1;
            #1 check(int'(v.req), host_rdata, v.exp);
            step();
         end
         OP_WAIT: begin
            for (int k = 0; k < int'(v.data); k++) step();
         end
         OP_SET: begin
            tgt_status = v.data[15:8];
            evt_async  = v.data[N_EVT-1:0];
            step();
         end
         default: begin
            #1 check(int'(v.req), {15'd0, host_irq}, v.exp);
            step();
         end
      endcase
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // directed: reset in the middle of activity clears everything (R1)
      evt_async = 2'b11;
      repeat (4) step();
      run_vec(mk(OP_WR, A_INTV, 2, 0, 0));
      rst_n = 1'b0;
      step();
      evt_async = '0;
      #1 check(1, {15'd0, host_irq}, 16'h0000);  // R1: irq low in reset
      rst_n = 1'b1;
      step();
      run_vec(mk(OP_RD, A_PEND, 0, 16'h0000, 1));  // R1
      run_vec(mk(OP_RD, A_MASK, 0, 16'h0000, 1));  // R1
      run_vec(mk(OP_RD, A_INTV, 0, 16'h0000, 1));  // R1
      run_vec(mk(OP_RD, A_INFO, 0, 16'h0000, 1));  // R1
      run_vec(mk(OP_RD, A_SNPO, 0, 16'h0000, 1));  // R1

      // directed: capture and read on the same edge keeps the flag (R5)
      tgt_status = 8'h5C;
      run_vec(mk(OP_WR, A_INTV, 2, 0, 0));
      step();
      run_vec(mk(OP_RD, A_INFO, 0, 16'h0000, 5));  // read meets capture
      run_vec(mk(OP_RD, A_INFO, 0, 16'h8001, 5));  // R5: flag survived
      run_vec(mk(OP_RD, A_SNPT, 0, 16'h005C, 2));  // R2
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end
endmodule